// File: doc/BRIEF.md
# Clock Synthesizer Divider Solver

This unit turns a requested output clock period into divider settings for a frequency synthesizer. It takes a reference clock period, a reference divider and a target period. From these it forms a scaled ratio, in eighths of a feedback divider step. It then picks a post-divider code by testing the ratio against power-of-two thresholds, looks up the real post-divide value and derives the feedback divider. A ratio outside the range the loop can lock to is flagged instead.

As a second step, the unit works out the frequency the settings produce. If a nonzero ceiling is given, it halves that frequency up to twice until it no longer exceeds the ceiling. The number of halvings is the scaler divider. It is packed with fixed low bits into a control byte for a pixel-clock control register.

Operation is a start/done handshake. One shared restoring divider does both divisions, so every request takes the same number of cycles. All operands are captured when a request is accepted.

Top module: `pll_div_solver`

## Requirements
- R1: `ratio` equals floor(`ref_per` * `ref_div` * 4 / `tgt_per`). A zero `tgt_per` gives an all-ones ratio.
- R2: When the ratio is below 128 or above 2040, `range_err` is 1 and `post_code`, `post_real`, `fb_div`, `scl_div` and `vclk_ctl` are all 0. Otherwise `range_err` is 0.
- R3: For an in-range ratio, `post_code` is the number of true tests among ratio<1024, ratio<512 and ratio<256, so it takes a value from 0 to 3.
- R4: `post_real` is entry `post_code` of the table {1, 2, 4, 8, 3}: code 0 gives 1, code 1 gives 2, code 2 gives 4 and code 3 gives 8.
- R5: `fb_div` equals floor(ratio * `post_real` / 8).
- R6: `scl_div` is found as follows. Let F = floor(floor(2*SCALE*`fb_div` / (`ref_per`*`ref_div`)) / `post_real`) and let the divider start at 0. While F > `scl_max` and the divider is below 2, F is halved (truncating) and the divider increases by 1. A `scl_max` of 0 forces the divider to 0.
- R7: For an in-range ratio, `vclk_ctl` is `scl_div` placed at bits 5:4, with bits 1:0 set to 2'b11 and all other bits 0.
- R8: The request is accepted on the clock edge where `start` is sampled high while `busy` is 0. `done` is a single-cycle pulse that rises exactly 2*NW+2 clock edges after that edge, and `busy` is 0 in the `done` cycle.
- R9: A `start` while `busy` is 1 is ignored. So are operand changes after acceptance. Neither changes the results or the latency of the request in flight.
- R10: After reset, `done`, `busy`, `range_err` and all result outputs are 0. Results change only in the cycle `done` is 1 and hold until the next `done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request pulse |
| ref_per | input | PW | Reference clock period |
| ref_div | input | RW | Reference divider |
| tgt_per | input | PW | Target clock period |
| scl_max | input | MW | Scaler frequency ceiling, 0 disables |
| busy | output | 1 | Request in progress |
| done | output | 1 | Results valid pulse |
| range_err | output | 1 | Ratio outside lockable range |
| ratio | output | NW | Scaled ratio in eighths |
| post_code | output | 3 | Post-divider code |
| post_real | output | 4 | Real post-divide value |
| fb_div | output | 8 | Feedback divider |
| scl_div | output | 2 | Scaler divider |
| vclk_ctl | output | 8 | Packed pixel-clock control byte |

## Verification
Every result becomes visible in the same cycle, 2*NW+2 edges after the accepting edge (66 at defaults). `done` drops one cycle later. After each accepting edge the bench counts rising edges and samples on the falling edge. It checks that `done` appears exactly at the expected count and compares all results in that cycle. It then checks that `done` is low one cycle later. Requests that receive a second `start` and fresh operands in mid-flight must still finish at the same count, with results from the first operands.

// File: rtl/pll_solver_pkg.sv
package pll_solver_pkg;

  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_DIV1 = 3'd1,
    S_EVAL = 3'd2,
    S_DIV2 = 3'd3,
    S_FIN  = 3'd4
  } solve_st_e;

  // lockable ratio window, in eighths of a feedback step
  localparam int unsigned RATIO_LO   = 128;
  localparam int unsigned RATIO_HI   = 2040;
  // lowest power-of-two threshold; further thresholds double it
  localparam int unsigned THR_BASE   = 256;
  localparam int          THR_COUNT  = 3;

  // post-divider table; entry 4 is a divide-by-three tap never picked by
  // the threshold count
  function automatic logic [3:0] post_lut(input logic [2:0] code);
    case (code)
      3'd0:    post_lut = 4'd1;
      3'd1:    post_lut = 4'd2;
      3'd2:    post_lut = 4'd4;
      3'd3:    post_lut = 4'd8;
      3'd4:    post_lut = 4'd3;
      default: post_lut = 4'd1;
    endcase
  endfunction

endpackage

// File: rtl/pll_rdiv.sv
module pll_rdiv #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         step,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic [W-1:0] quo
);

  logic [W-1:0] rem_q, rem_d;
  logic [W-1:0] quo_q, quo_d;
  logic [W-1:0] dvs_q, dvs_d;
  logic [W:0]   trial;

  // one quotient bit per step, most significant first
  always_comb begin
    rem_d = rem_q;
    quo_d = quo_q;
    dvs_d = dvs_q;
    trial = {rem_q, quo_q[W-1]} - {1'b0, dvs_q};
    if (load) begin
      rem_d = '0;
      quo_d = dividend;
      dvs_d = divisor;
    end else if (step) begin
      if (!trial[W]) rem_d = trial[W-1:0];
      else           rem_d = {rem_q[W-2:0], quo_q[W-1]};
      quo_d = {quo_q[W-2:0], ~trial[W]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      quo_q <= '0;
      dvs_q <= '0;
    end else if (load || step) begin
      rem_q <= rem_d;
      quo_q <= quo_d;
      dvs_q <= dvs_d;
    end
  end

  assign quo = quo_q;

endmodule

// File: rtl/pll_sel.sv
module pll_sel
  import pll_solver_pkg::*;
#(
  parameter int NW = 32
) (
  input  logic [NW-1:0] q,
  output logic          oor,
  output logic [2:0]    code,
  output logic [3:0]    preal,
  output logic [7:0]    fb
);

  logic [14:0] prod;

  always_comb begin
    oor  = (q < NW'(RATIO_LO)) || (q > NW'(RATIO_HI));
    code = 3'd0;
    for (int i = 0; i < THR_COUNT; i++) begin
      if (q < (NW'(THR_BASE) << i)) code = code + 3'd1;
    end
    preal = post_lut(code);
    prod  = 15'(q[10:0]) * 15'(preal);
    if (oor) begin
      code  = 3'd0;
      preal = 4'd0;
      fb    = 8'd0;
    end else begin
      fb    = prod[10:3];
    end
  end

endmodule

// File: rtl/pll_scl.sv
module pll_scl #(
  parameter int FW    = 32,
  parameter int MW    = 24,
  parameter int STEPS = 2,
  localparam int DW   = $clog2(STEPS + 1)
) (
  input  logic [FW-1:0] freq,
  input  logic [MW-1:0] fmax,
  output logic [DW-1:0] div
);

  logic [FW-1:0] f;

  // unrolled halving; the step bound is the loop bound
  always_comb begin
    f   = freq;
    div = '0;
    for (int i = 0; i < STEPS; i++) begin
      if ((fmax != '0) && (f > FW'(fmax))) begin
        f   = f >> 1;
        div = div + DW'(1);
      end
    end
  end

endmodule

// File: rtl/pll_div_solver.sv
module pll_div_solver
  import pll_solver_pkg::*;
#(
  parameter int PW    = 16,
  parameter int RW    = 8,
  parameter int MW    = 24,
  parameter int NW    = 32,
  parameter int SCALE = 1000000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [PW-1:0] ref_per,
  input  logic [RW-1:0] ref_div,
  input  logic [PW-1:0] tgt_per,
  input  logic [MW-1:0] scl_max,
  output logic          busy,
  output logic          done,
  output logic          range_err,
  output logic [NW-1:0] ratio,
  output logic [2:0]    post_code,
  output logic [3:0]    post_real,
  output logic [7:0]    fb_div,
  output logic [1:0]    scl_div,
  output logic [7:0]    vclk_ctl
);

  localparam int PRW = PW + RW;
  localparam int CW  = $clog2(NW);
  localparam logic [NW-1:0] NUM_K = NW'(2 * SCALE);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rs_q;
  logic       rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_s = rs_q[1];

  solve_st_e st_q, st_d;
  logic [CW-1:0]  cnt_q, cnt_d;
  logic [PRW-1:0] prod_in, prod_q;
  logic [MW-1:0]  max_q;
  logic           cap_en, eval_en, fin_en;

  logic           d_load, d_step;
  logic [NW-1:0]  d_dividend, d_divisor, d_quo;

  logic           sel_oor;
  logic [2:0]     sel_code;
  logic [3:0]     sel_real;
  logic [7:0]     sel_fb;

  logic [NW-1:0]  q_q;
  logic           oor_q;
  logic [2:0]     code_q;
  logic [3:0]     real_q;
  logic [NW-1:0]  freq;
  logic [1:0]     scl_w;

  logic           done_q, err_q;
  logic [NW-1:0]  ratio_q;
  logic [2:0]     pcode_q;
  logic [3:0]     preal_q;
  logic [7:0]     fb_q, ctl_q;
  logic [1:0]     scl_q;

  assign prod_in = PRW'(ref_per) * PRW'(ref_div);

  // next-state
  always_comb begin
    st_d       = st_q;
    cnt_d      = cnt_q;
    d_load     = 1'b0;
    d_step     = 1'b0;
    d_dividend = '0;
    d_divisor  = '0;
    cap_en     = 1'b0;
    eval_en    = 1'b0;
    fin_en     = 1'b0;
    case (st_q)
      S_IDLE: begin
        if (start) begin
          d_load     = 1'b1;
          d_dividend = NW'({prod_in, 2'b00});
          d_divisor  = NW'(tgt_per);
          cap_en     = 1'b1;
          cnt_d      = '0;
          st_d       = S_DIV1;
        end
      end
      S_DIV1, S_DIV2: begin
        d_step = 1'b1;
        if (cnt_q == CW'(NW - 1)) begin
          cnt_d = '0;
          st_d  = (st_q == S_DIV1) ? S_EVAL : S_FIN;
        end else begin
          cnt_d = cnt_q + CW'(1);
        end
      end
      S_EVAL: begin
        d_load     = 1'b1;
        d_dividend = NUM_K * NW'(sel_fb);
        d_divisor  = NW'(prod_q);
        eval_en    = 1'b1;
        st_d       = S_DIV2;
      end
      S_FIN: begin
        fin_en = 1'b1;
        st_d   = S_IDLE;
      end
      default: st_d = S_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      st_q  <= S_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      prod_q <= '0;
      max_q  <= '0;
    end else if (cap_en) begin
      prod_q <= prod_in;
      max_q  <= scl_max;
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      q_q    <= '0;
      oor_q  <= 1'b0;
      code_q <= '0;
      real_q <= '0;
    end else if (eval_en) begin
      q_q    <= d_quo;
      oor_q  <= sel_oor;
      code_q <= sel_code;
      real_q <= sel_real;
    end
  end

  pll_rdiv #(.W(NW)) u_div (
    .clk      (clk),
    .rst_n    (rst_s),
    .load     (d_load),
    .step     (d_step),
    .dividend (d_dividend),
    .divisor  (d_divisor),
    .quo      (d_quo)
  );

  pll_sel #(.NW(NW)) u_sel (
    .q     (d_quo),
    .oor   (sel_oor),
    .code  (sel_code),
    .preal (sel_real),
    .fb    (sel_fb)
  );

  // in-range real values are powers of two, so the second divide is a shift
  assign freq = d_quo >> code_q;

  pll_scl #(.FW(NW), .MW(MW), .STEPS(2)) u_scl (
    .freq (freq),
    .fmax (max_q),
    .div  (scl_w)
  );

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      done_q <= 1'b0;
    end else begin
      done_q <= fin_en;
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      err_q   <= 1'b0;
      ratio_q <= '0;
      pcode_q <= '0;
      preal_q <= '0;
      fb_q    <= '0;
      scl_q   <= '0;
      ctl_q   <= '0;
    end else if (fin_en) begin
      err_q   <= oor_q;
      ratio_q <= q_q;
      if (oor_q) begin
        pcode_q <= '0;
        preal_q <= '0;
        fb_q    <= '0;
        scl_q   <= '0;
        ctl_q   <= '0;
      end else begin
        pcode_q <= code_q;
        preal_q <= real_q;
        fb_q    <= q_q[10:0] * 11'(real_q) >> 3;
        scl_q   <= scl_w;
        ctl_q   <= {2'b00, scl_w, 4'b0011};
      end
    end
  end

  assign busy      = (st_q != S_IDLE);
  assign done      = done_q;
  assign range_err = err_q;
  assign ratio     = ratio_q;
  assign post_code = pcode_q;
  assign post_real = preal_q;
  assign fb_div    = fb_q;
  assign scl_div   = scl_q;
  assign vclk_ctl  = ctl_q;

  // assertions
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_s)
    done |=> !done);
  p_idle_at_done_r8: assert property (@(posedge clk) disable iff (!rst_s)
    done |-> !busy);
  p_err_clears_r2: assert property (@(posedge clk) disable iff (!rst_s)
    (done && range_err) |-> (fb_div == 8'd0 && vclk_ctl == 8'd0 && post_real == 4'd0));
  p_ctl_low_r7: assert property (@(posedge clk) disable iff (!rst_s)
    (done && !range_err) |-> (vclk_ctl[1:0] == 2'b11 && vclk_ctl[5:4] == scl_div));
  p_code_span_r3: assert property (@(posedge clk) disable iff (!rst_s)
    (done && !range_err) |-> (post_code <= 3'd3 && $onehot0(post_real)));
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_s)
    !done |-> ($stable(fb_div) && $stable(ratio) && $stable(vclk_ctl)));

endmodule

// File: tb/sim_pll_div_solver.sv
module sim_pll_div_solver;

  localparam int CLK_NS = 10;
  localparam int NW     = 32;
  localparam int LAT    = 2 * NW + 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] ref_per = '0;
  logic [7:0]  ref_div = '0;
  logic [15:0] tgt_per = '0;
  logic [23:0] scl_max = '0;
  logic        busy, done, range_err;
  logic [31:0] ratio;
  logic [2:0]  post_code;
  logic [3:0]  post_real;
  logic [7:0]  fb_div, vclk_ctl;
  logic [1:0]  scl_div;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_NS / 2) clk = ~clk;

  pll_div_solver u0 (
    .clk(clk), .rst_n(rst_n), .start(start),
    .ref_per(ref_per), .ref_div(ref_div), .tgt_per(tgt_per), .scl_max(scl_max),
    .busy(busy), .done(done), .range_err(range_err), .ratio(ratio),
    .post_code(post_code), .post_real(post_real), .fb_div(fb_div),
    .scl_div(scl_div), .vclk_ctl(vclk_ctl)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  task automatic run(input longint rp, input longint rd, input longint tp,
                     input longint mx, input bit inject);
    longint prod, q, code, pr, fb, f, d, ctl;
    bit     oor;
    int     cyc;
    prod = rp * rd;
    q    = (tp == 0) ? 64'hFFFF_FFFF : (prod * 4) / tp;
    oor  = (q < 128) || (q > 2040);
    code = 0; pr = 0; fb = 0; d = 0; ctl = 0;
    if (!oor) begin
      code = longint'(q < 1024) + longint'(q < 512) + longint'(q < 256);
      pr   = 64'd1 << code;
      fb   = (q * pr) / 8;
      f    = ((2 * 1000000 * fb) / prod) / pr;
      if (mx != 0) begin
        while (f > mx && d < 2) begin
          f = f >> 1;
          d++;
        end
      end
      ctl = (d << 4) | 3;
    end
    @(negedge clk);
    ref_per = 16'(rp); ref_div = 8'(rd); tgt_per = 16'(tp); scl_max = 24'(mx);
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    while (cyc < 400) begin
      @(posedge clk);
      cyc++;
      @(negedge clk);
      if (done) break;
      if (inject && cyc == 10) begin
        start = 1'b1; ref_per = 16'd7; ref_div = 8'd3; tgt_per = 16'd1; scl_max = 24'd1;
      end
      if (inject && cyc == 11) start = 1'b0;
    end
    chk(inject ? "R9 latency with start while busy" : "R8 done latency", cyc, LAT);
    chk("R8 busy low at done", busy, 0);
    chk(inject ? "R9 ratio kept" : "R1 ratio", ratio, q & 64'hFFFF_FFFF);
    chk("R2 range flag", range_err, oor);
    chk("R3 post code", post_code, code);
    chk("R4 post real", post_real, pr);
    chk("R5 feedback div", fb_div, fb);
    chk("R6 scaler div", scl_div, d);
    chk("R7 control byte", vclk_ctl, ctl);
    @(posedge clk);
    @(negedge clk);
    chk("R8 done single pulse", done, 0);
    chk("R10 results held", fb_div, fb);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    longint refs_p [3] = '{2000, 331, 6000};
    longint refs_d [3] = '{1, 7, 255};
    longint maxes  [4] = '{0, 40000, 90000, 7};
    longint edges  [12] = '{127, 128, 255, 256, 511, 512, 1023, 1024, 2040, 2041, 1000, 300};
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 done after reset", done, 0);
    chk("R10 busy after reset", busy, 0);
    chk("R10 range flag after reset", range_err, 0);
    chk("R10 fb after reset", fb_div, 0);
    chk("R10 ctl after reset", vclk_ctl, 0);

    // R2 R3 threshold boundaries: ratio = ref_per exactly
    for (int i = 0; i < 12; i++) run(edges[i], 1, 4, 50000, 1'b0);
    // R1 zero target period
    run(2000, 1, 0, 0, 1'b0);

    // sweep across references, ratios and ceilings
    for (int r = 0; r < 3; r++) begin
      for (int m = 0; m < 4; m++) begin
        for (int t = 0; t < 60; t++) begin
          longint prod, tp;
          prod = refs_p[r] * refs_d[r];
          tp   = (t == 0) ? 1 : ((prod * 4) / (64 + t * 40) + (t % 3));
          tp   = tp & 64'hFFFF;
          if (tp == 0) tp = 1;
          run(refs_p[r], refs_d[r], tp, maxes[m], 1'b0);
        end
      end
    end

    // R9 start and operand changes while busy
    run(2000, 1, 8, 40000, 1'b1);
    run(331, 7, 20, 0, 1'b1);
    run(edges[0], 1, 4, 0, 1'b1);

    finish_run();
  end

endmodule